// File: doc/BRIEF.md
# Rotating-Parity Small-Write Controller

This block accepts single-block logical writes and turns each one into a read-modify-write on an array of five disks. Every stripe holds four data blocks and one parity block. The parity position moves by one disk from each stripe to the next, so parity traffic is spread over the whole array. For each write the block finds the stripe, the disk that holds the addressed data block and the disk that holds that stripe's parity. It reads the old data and the old parity, forms the new parity from the change in data, and writes the new data and the new parity back.

Each disk sits behind a synchronous request/acknowledge port. Requests are held until they are acknowledged. Two write engines run side by side. A second write starts only when its two disks share nothing with the write already in progress. While the write offered at the input cannot start, the input reports not ready. Each engine signals completion on its own bit of the done vector.

Top module: `rp_stripe_writer`

## Requirements
- R1: For logical block index L, the stripe is s = L/4 (integer division). The parity disk is 4 − (s mod 5), with disks numbered 0..4. Every disk access made for that write addresses block s on its disk.
- R2: With k = L mod 4, the data disk is the k-th disk in ascending order among the four disks that do not hold parity for stripe s.
- R3: A write first issues read requests (disk_we = 0) to its data disk and its parity disk. No write request (disk_we = 1) is issued for it until both reads have been acknowledged.
- R4: The data disk is written with the new word. The parity disk is written with old parity XOR old data XOR new word. As a result, every stripe's five blocks XOR to zero at all times when no write is in flight.
- R5: Each logical write makes exactly four physical accesses: one read and one write on its data disk, and one read and one write on its parity disk.
- R6: Completion is a single-cycle pulse on wr_done[j]. It is raised in the cycle after the clock edge that captures the last of the two write acknowledgements, and never earlier.
- R7: Two writes whose disk pairs are disjoint are in flight at the same time, with outstanding requests from both in one cycle.
- R8: wr_ready is high exactly when some engine is idle and the disk pair of wr_lba shares no disk with any busy engine. An engine counts as busy through its done cycle. A write is taken on a clock edge where wr_valid and wr_ready are both high.
- R9: A write that is taken goes to the lowest-numbered idle engine, and its completion is reported on that engine's bit of wr_done.
- R10: While reset is held, disk_req and wr_done are all zero and wr_ready is high.
- R11: A disk request, once raised, stays raised until acknowledged. Its block address and direction do not change while it waits, and neither does its write data when it is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A logical write is offered |
| wr_lba | input | LBA_W | Logical block index of the offered write |
| wr_data | input | DW | New data word |
| wr_ready | output | 1 | The offered write can be taken this cycle |
| wr_done | output | NSLOT | Per-engine completion pulse |
| disk_req | output | 5 | Per-disk request |
| disk_we | output | 5 | Per-disk direction, 1 = write |
| disk_addr | output | 5*(LBA_W-2) | Per-disk block address (stripe number) |
| disk_wdata | output | 5*DW | Per-disk write data |
| disk_ack | input | 5 | Per-disk acknowledge, one cycle |
| disk_rdata | input | 5*DW | Per-disk read data, valid with acknowledge |

## Verification
The hardest situation to reach is a third write that arrives while two disjoint writes are both active, and that overlaps one of them on a single disk. That write must stall until exactly the matching done cycle has passed. The stimulus reaches it with a directed pair of blocks whose disk pairs are disjoint, followed at once by a block in the first write's stripe. Disk models with random acknowledge delay then keep the two engines out of step. A long random stream with idle gaps, over a 64-block space, produces many more partial overlaps. Parity consistency of every stripe is checked against a behavioural image once the run has drained.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int NDISK  = 5;
  localparam int DIDX_W = 3;

  typedef logic [DIDX_W-1:0] didx_t;

  typedef enum logic [1:0] {
    SL_IDLE,
    SL_READ,
    SL_WRITE,
    SL_FIN
  } slot_st_e;
endpackage

// File: rtl/rp_stripe_map.sv
module rp_stripe_map
  import rp_pkg::*;
#(
  parameter int LBA_W = 6,
  localparam int SA_W = LBA_W - 2
) (
  input  logic [LBA_W-1:0] lba,
  output logic [SA_W-1:0]  stripe,
  output didx_t            ddisk,
  output didx_t            pdisk,
  output logic [NDISK-1:0] dmask
);
  logic [31:0] rot;
  didx_t       kpos;

  always_comb begin
    stripe = lba[LBA_W-1:2];
    rot    = 32'(stripe) % 32'(NDISK);
    // parity walks downward one disk per stripe
    pdisk  = didx_t'(32'(NDISK - 1) - rot);
    kpos   = {1'b0, lba[1:0]};
    // data blocks skip over the parity disk
    ddisk  = (kpos < pdisk) ? kpos : didx_t'(kpos + didx_t'(1));
    dmask  = (NDISK'(1) << ddisk) | (NDISK'(1) << pdisk);
  end
endmodule

// File: rtl/rp_rmw_slot.sv
module rp_rmw_slot
  import rp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int SA_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SA_W-1:0]  st_stripe,
  input  didx_t            st_dd,
  input  didx_t            st_pd,
  input  logic [DW-1:0]    st_data,
  input  logic             ack_d,
  input  logic             ack_p,
  input  logic [DW-1:0]    rdata_d,
  input  logic [DW-1:0]    rdata_p,
  output logic             busy,
  output logic [NDISK-1:0] mask,
  output didx_t            dd,
  output didx_t            pd,
  output logic [SA_W-1:0]  stripe,
  output logic             req_d,
  output logic             req_p,
  output logic             we,
  output logic [DW-1:0]    wdata_d,
  output logic [DW-1:0]    wdata_p,
  output logic             done
);
  slot_st_e        state_q, state_d;
  logic            gotd_q, gotd_d, gotp_q, gotp_d;
  logic            load_en, capd_en, capp_en;
  logic [SA_W-1:0] stripe_q;
  didx_t           dd_q, pd_q;
  logic [DW-1:0]   new_q, oldd_q, oldp_q;
  logic            active;

  // request outputs depend only on registered state
  always_comb begin
    active  = (state_q == SL_READ) || (state_q == SL_WRITE);
    req_d   = active && !gotd_q;
    req_p   = active && !gotp_q;
    we      = (state_q == SL_WRITE);
    busy    = (state_q != SL_IDLE);
    done    = (state_q == SL_FIN);
    dd      = dd_q;
    pd      = pd_q;
    stripe  = stripe_q;
    wdata_d = new_q;
    wdata_p = oldp_q ^ oldd_q ^ new_q;
    mask    = busy ? ((NDISK'(1) << dd_q) | (NDISK'(1) << pd_q)) : '0;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    gotd_d  = gotd_q;
    gotp_d  = gotp_q;
    load_en = 1'b0;
    capd_en = 1'b0;
    capp_en = 1'b0;
    unique case (state_q)
      SL_IDLE: begin
        if (start) begin
          state_d = SL_READ;
          load_en = 1'b1;
          gotd_d  = 1'b0;
          gotp_d  = 1'b0;
        end
      end
      SL_READ, SL_WRITE: begin
        if (req_d && ack_d) begin
          gotd_d  = 1'b1;
          capd_en = (state_q == SL_READ);
        end
        if (req_p && ack_p) begin
          gotp_d  = 1'b1;
          capp_en = (state_q == SL_READ);
        end
        if ((gotd_q || (req_d && ack_d)) && (gotp_q || (req_p && ack_p))) begin
          state_d = (state_q == SL_READ) ? SL_WRITE : SL_FIN;
          gotd_d  = 1'b0;
          gotp_d  = 1'b0;
        end
      end
      SL_FIN: state_d = SL_IDLE;
      default: state_d = SL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_IDLE;
      gotd_q  <= 1'b0;
      gotp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gotd_q  <= gotd_d;
      gotp_q  <= gotp_d;
    end
  end

  // datapath registers: explicit enables, no reset needed
  always_ff @(posedge clk) begin
    if (load_en) begin
      stripe_q <= st_stripe;
      dd_q     <= st_dd;
      pd_q     <= st_pd;
      new_q    <= st_data;
    end
    if (capd_en) oldd_q <= rdata_d;
    if (capp_en) oldp_q <= rdata_p;
  end
endmodule

// File: rtl/rp_disk_xbar.sv
module rp_disk_xbar
  import rp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SA_W  = 4,
  parameter int NSLOT = 2
) (
  input  logic [NSLOT-1:0]                 sl_req_d,
  input  logic [NSLOT-1:0]                 sl_req_p,
  input  logic [NSLOT-1:0]                 sl_we,
  input  logic [NSLOT-1:0][DIDX_W-1:0]     sl_dd,
  input  logic [NSLOT-1:0][DIDX_W-1:0]     sl_pd,
  input  logic [NSLOT-1:0][SA_W-1:0]       sl_stripe,
  input  logic [NSLOT-1:0][DW-1:0]         sl_wdd,
  input  logic [NSLOT-1:0][DW-1:0]         sl_wdp,
  output logic [NSLOT-1:0]                 sl_ack_d,
  output logic [NSLOT-1:0]                 sl_ack_p,
  output logic [NSLOT-1:0][DW-1:0]         sl_rdd,
  output logic [NSLOT-1:0][DW-1:0]         sl_rdp,
  output logic [NDISK-1:0]                 x_req,
  output logic [NDISK-1:0]                 x_we,
  output logic [NDISK-1:0][SA_W-1:0]       x_addr,
  output logic [NDISK-1:0][DW-1:0]         x_wd,
  input  logic [NDISK-1:0]                 x_ack,
  input  logic [NDISK-1:0][DW-1:0]         x_rd
);
  // admission keeps slot disk sets disjoint, so each disk has one owner
  always_comb begin
    x_req  = '0;
    x_we   = '0;
    x_addr = '0;
    x_wd   = '0;
    for (int i = 0; i < NDISK; i++) begin
      for (int j = 0; j < NSLOT; j++) begin
        if (sl_req_d[j] && (sl_dd[j] == DIDX_W'(i))) begin
          x_req[i]  = 1'b1;
          x_we[i]   = sl_we[j];
          x_addr[i] = sl_stripe[j];
          x_wd[i]   = sl_wdd[j];
        end
        if (sl_req_p[j] && (sl_pd[j] == DIDX_W'(i))) begin
          x_req[i]  = 1'b1;
          x_we[i]   = sl_we[j];
          x_addr[i] = sl_stripe[j];
          x_wd[i]   = sl_wdp[j];
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NSLOT; j++) begin
      sl_ack_d[j] = x_ack[sl_dd[j]];
      sl_ack_p[j] = x_ack[sl_pd[j]];
      sl_rdd[j]   = x_rd[sl_dd[j]];
      sl_rdp[j]   = x_rd[sl_pd[j]];
    end
  end
endmodule

// File: rtl/rp_stripe_writer.sv
module rp_stripe_writer
  import rp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LBA_W = 6,
  parameter int NSLOT = 2,
  localparam int SA_W = LBA_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [LBA_W-1:0]       wr_lba,
  input  logic [DW-1:0]          wr_data,
  output logic                   wr_ready,
  output logic [NSLOT-1:0]       wr_done,
  output logic [NDISK-1:0]       disk_req,
  output logic [NDISK-1:0]       disk_we,
  output logic [NDISK*SA_W-1:0]  disk_addr,
  output logic [NDISK*DW-1:0]    disk_wdata,
  input  logic [NDISK-1:0]       disk_ack,
  input  logic [NDISK*DW-1:0]    disk_rdata
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [SA_W-1:0]  in_stripe;
  didx_t            in_dd, in_pd;
  logic [NDISK-1:0] in_mask;

  rp_stripe_map #(.LBA_W(LBA_W)) u_map (
    .lba(wr_lba), .stripe(in_stripe), .ddisk(in_dd), .pdisk(in_pd), .dmask(in_mask)
  );

  logic [NSLOT-1:0]             sl_busy, sl_start, sl_req_d, sl_req_p, sl_we, sl_done;
  logic [NSLOT-1:0]             sl_ack_d, sl_ack_p, sel_oh;
  logic [NSLOT-1:0][DIDX_W-1:0] sl_dd, sl_pd;
  logic [NSLOT-1:0][SA_W-1:0]   sl_stripe;
  logic [NSLOT-1:0][DW-1:0]     sl_wdd, sl_wdp, sl_rdd, sl_rdp;
  logic [NSLOT-1:0][NDISK-1:0]  slot_mask;
  logic [NDISK-1:0]             busy_disks;
  logic                         have_idle, accept;

  // admission: lowest idle engine (R9), disjoint disk pair (R8)
  always_comb begin
    sel_oh     = '0;
    have_idle  = 1'b0;
    busy_disks = '0;
    for (int j = 0; j < NSLOT; j++) begin
      busy_disks = busy_disks | slot_mask[j];
      if (!sl_busy[j] && !have_idle) begin
        sel_oh[j] = 1'b1;
        have_idle = 1'b1;
      end
    end
    wr_ready = have_idle && ((in_mask & busy_disks) == '0);
    accept   = wr_valid && wr_ready;
    sl_start = accept ? sel_oh : '0;
  end

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    rp_rmw_slot #(.DW(DW), .SA_W(SA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .start    (sl_start[j]),
      .st_stripe(in_stripe),
      .st_dd    (in_dd),
      .st_pd    (in_pd),
      .st_data  (wr_data),
      .ack_d    (sl_ack_d[j]),
      .ack_p    (sl_ack_p[j]),
      .rdata_d  (sl_rdd[j]),
      .rdata_p  (sl_rdp[j]),
      .busy     (sl_busy[j]),
      .mask     (slot_mask[j]),
      .dd       (sl_dd[j]),
      .pd       (sl_pd[j]),
      .stripe   (sl_stripe[j]),
      .req_d    (sl_req_d[j]),
      .req_p    (sl_req_p[j]),
      .we       (sl_we[j]),
      .wdata_d  (sl_wdd[j]),
      .wdata_p  (sl_wdp[j]),
      .done     (sl_done[j])
    );
  end

  logic [NDISK-1:0][SA_W-1:0] x_addr;
  logic [NDISK-1:0][DW-1:0]   x_wd, x_rd;

  assign x_rd = disk_rdata;

  rp_disk_xbar #(.DW(DW), .SA_W(SA_W), .NSLOT(NSLOT)) u_xbar (
    .sl_req_d (sl_req_d),
    .sl_req_p (sl_req_p),
    .sl_we    (sl_we),
    .sl_dd    (sl_dd),
    .sl_pd    (sl_pd),
    .sl_stripe(sl_stripe),
    .sl_wdd   (sl_wdd),
    .sl_wdp   (sl_wdp),
    .sl_ack_d (sl_ack_d),
    .sl_ack_p (sl_ack_p),
    .sl_rdd   (sl_rdd),
    .sl_rdp   (sl_rdp),
    .x_req    (disk_req),
    .x_we     (disk_we),
    .x_addr   (x_addr),
    .x_wd     (x_wd),
    .x_ack    (disk_ack),
    .x_rd     (x_rd)
  );

  assign disk_addr  = x_addr;
  assign disk_wdata = x_wd;
  assign wr_done    = sl_done;
endmodule

// File: rtl/rp_stripe_writer_chk.sv
module rp_stripe_writer_chk #(
  parameter int DW    = 16,
  parameter int SA_W  = 4,
  parameter int NSLOT = 2,
  parameter int NDISK = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NSLOT-1:0]              wr_done,
  input logic [NDISK-1:0]              disk_req,
  input logic [NDISK-1:0]              disk_we,
  input logic [NDISK-1:0]              disk_ack,
  input logic [NDISK*SA_W-1:0]         disk_addr,
  input logic [NDISK*DW-1:0]           disk_wdata,
  input logic [NSLOT-1:0][NDISK-1:0]   slot_mask
);
  for (genvar i = 0; i < NDISK; i++) begin : g_disk
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disk_req[i] && !disk_ack[i]) |=> disk_req[i]);
    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disk_req[i] && !disk_ack[i]) |=>
        ($stable(disk_addr[i*SA_W +: SA_W]) && $stable(disk_we[i])));
    // R11
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disk_req[i] && disk_we[i] && !disk_ack[i]) |=> $stable(disk_wdata[i*DW +: DW]));
  end

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[j] |=> !wr_done[j]);
    // R5
    pair_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(slot_mask[j]) == 0) || ($countones(slot_mask[j]) == 2));
    for (genvar k = j + 1; k < NSLOT; k++) begin : g_other
      // R8
      slot_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_mask[j] & slot_mask[k]) == '0);
    end
  end
endmodule

bind rp_stripe_writer rp_stripe_writer_chk #(
  .DW(DW), .SA_W(SA_W), .NSLOT(NSLOT), .NDISK(rp_pkg::NDISK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_done   (wr_done),
  .disk_req  (disk_req),
  .disk_we   (disk_we),
  .disk_ack  (disk_ack),
  .disk_addr (disk_addr),
  .disk_wdata(disk_wdata),
  .slot_mask (slot_mask)
);

// File: tb/rp_stripe_writer_tb.sv
module rp_stripe_writer_tb;
  localparam int DW    = 16;
  localparam int LBA_W = 6;
  localparam int NSLOT = 2;
  localparam int SA_W  = LBA_W - 2;
  localparam int ND    = 5;
  localparam int NSTR  = 1 << SA_W;
  localparam int NBLK  = 1 << LBA_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic                 wr_valid;
  logic [LBA_W-1:0]     wr_lba;
  logic [DW-1:0]        wr_data;
  logic                 wr_ready;
  logic [NSLOT-1:0]     wr_done;
  logic [ND-1:0]        disk_req, disk_we, disk_ack;
  logic [ND*SA_W-1:0]   disk_addr;
  logic [ND*DW-1:0]     disk_wdata, disk_rdata;

  rp_stripe_writer #(.DW(DW), .LBA_W(LBA_W), .NSLOT(NSLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_lba(wr_lba), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_done(wr_done), .disk_req(disk_req), .disk_we(disk_we),
    .disk_addr(disk_addr), .disk_wdata(disk_wdata), .disk_ack(disk_ack),
    .disk_rdata(disk_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] mem [ND][NSTR];
  logic [DW-1:0] img [NBLK];
  int            q_lba[$];
  logic [DW-1:0] q_dat[$];

  // disk models
  bit pend [ND];
  int lat  [ND];
  int pa   [ND];
  bit pw   [ND];

  // reference engines
  bit            mb [NSLOT];
  int            ms [NSLOT], mdd [NSLOT], mpd [NSLOT], mrd [NSLOT], mwr [NSLOT];
  bit            mexp [NSLOT], rdd [NSLOT], rdp [NSLOT], wrd [NSLOT], wrp [NSLOT];
  logic [DW-1:0] mnew [NSLOT], mpar [NSLOT];
  bit            hold = 0;
  int            ovl = 0;
  int            stalls = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pdisk_of(input int s);
    return 4 - (s % 5);
  endfunction

  function automatic int ddisk_of(input int lba);
    int p = pdisk_of(lba / 4);
    int k = lba % 4;
    return (k < p) ? k : k + 1;
  endfunction

  function automatic logic [ND-1:0] mask_of(input int d, input int p);
    int m = (1 << d) | (1 << p);
    return ND'(m);
  endfunction

  task automatic do_access(input int i);
    int j = -1;
    int a;
    logic [DW-1:0] exp;
    a = int'(disk_addr[i*SA_W +: SA_W]);
    for (int jj = 0; jj < NSLOT; jj++)
      if (mb[jj] && (mdd[jj] == i || mpd[jj] == i)) j = jj;
    if (j < 0) begin
      chk(0, "R1 access on disk owned by no write", i, -1);
      return;
    end
    chk(a == ms[j], "R1 block address", a, ms[j]);
    if (!disk_we[i]) begin
      chk(mwr[j] == 0, "R3 read after write began", mwr[j], 0);
      if (i == mdd[j]) begin chk(!rdd[j], "R5 second data read", 1, 0); rdd[j] = 1; end
      else begin chk(!rdp[j], "R5 second parity read", 1, 0); rdp[j] = 1; end
      disk_rdata[i*DW +: DW] = mem[i][a];
      mrd[j]++;
    end else begin
      chk(mrd[j] == 2, "R3 write before both reads", mrd[j], 2);
      exp = (i == mdd[j]) ? mnew[j] : mpar[j];
      chk(disk_wdata[i*DW +: DW] == exp, "R4 write data", disk_wdata[i*DW +: DW], exp);
      if (i == mdd[j]) begin chk(!wrd[j], "R5 second data write", 1, 0); wrd[j] = 1; end
      else begin chk(!wrp[j], "R5 second parity write", 1, 0); wrp[j] = 1; end
      mem[i][a] = disk_wdata[i*DW +: DW];
      mwr[j]++;
      if (mwr[j] == 2) mexp[j] = 1;
    end
  endtask

  task automatic step();
    bit fr [NSLOT];
    bit have;
    logic [ND-1:0] busym, nm;
    logic [ND-1:0] m0, m1;
    int l, jsel, s;
    logic [DW-1:0] dat;
    @(negedge clk);
    // completions (R6, R9, R5)
    for (int j = 0; j < NSLOT; j++) begin
      fr[j] = 0;
      chk(wr_done[j] == mexp[j], "R6/R9 done on engine bit", wr_done[j], mexp[j]);
      if (wr_done[j] && mb[j]) begin
        chk(mrd[j] == 2 && mwr[j] == 2, "R5 four accesses", mrd[j] * 16 + mwr[j], 34);
        fr[j] = 1;
      end
      mexp[j] = 0;
    end
    // concurrency observation (R7)
    m0 = mb[0] ? mask_of(mdd[0], mpd[0]) : '0;
    m1 = mb[1] ? mask_of(mdd[1], mpd[1]) : '0;
    if (((disk_req & m0) != 0) && ((disk_req & m1) != 0)) ovl++;
    // disk models
    for (int i = 0; i < ND; i++) begin
      if (disk_ack[i]) begin
        disk_ack[i] = 1'b0;
      end else if (pend[i]) begin
        chk(disk_req[i] && disk_we[i] == pw[i] && int'(disk_addr[i*SA_W +: SA_W]) == pa[i],
            "R11 request held", disk_req[i], 1);
        if (lat[i] == 0) begin do_access(i); pend[i] = 0; disk_ack[i] = 1'b1; end
        else lat[i]--;
      end else if (disk_req[i]) begin
        lat[i] = int'($urandom_range(2, 0));
        pa[i]  = int'(disk_addr[i*SA_W +: SA_W]);
        pw[i]  = disk_we[i];
        if (lat[i] == 0) begin do_access(i); disk_ack[i] = 1'b1; end
        else begin pend[i] = 1; lat[i]--; end
      end
    end
    // drive the next offer
    if (!hold) begin
      if (q_lba.size() > 0) begin
        l = q_lba.pop_front();
        dat = q_dat.pop_front();
        if (l < 0) wr_valid = 1'b0;
        else begin wr_valid = 1'b1; wr_lba = LBA_W'(l); wr_data = dat; end
      end else wr_valid = 1'b0;
    end
    #1;
    // ready prediction (R8) and admission to the lowest idle engine (R9)
    l = int'(wr_lba);
    nm = mask_of(ddisk_of(l), pdisk_of(l / 4));
    busym = '0;
    have = 0;
    jsel = -1;
    for (int j = 0; j < NSLOT; j++) begin
      if (mb[j]) busym |= mask_of(mdd[j], mpd[j]);
      else if (jsel < 0) begin jsel = j; have = 1; end
    end
    chk(wr_ready == (have && ((nm & busym) == 0)), "R8 ready", wr_ready, have && ((nm & busym) == 0));
    if (wr_valid && wr_ready && jsel >= 0) begin
      s = l / 4;
      mb[jsel] = 1; ms[jsel] = s; mdd[jsel] = ddisk_of(l); mpd[jsel] = pdisk_of(s);
      mrd[jsel] = 0; mwr[jsel] = 0; mexp[jsel] = 0;
      rdd[jsel] = 0; rdp[jsel] = 0; wrd[jsel] = 0; wrp[jsel] = 0;
      mnew[jsel] = wr_data;
      mpar[jsel] = mem[mpd[jsel]][s] ^ mem[mdd[jsel]][s] ^ wr_data;
      img[l] = wr_data;
      hold = 0;
    end else begin
      hold = wr_valid;
      if (hold) stalls++;
    end
    for (int j = 0; j < NSLOT; j++) if (fr[j]) mb[j] = 0;
  endtask

  function automatic bit busy_any();
    for (int j = 0; j < NSLOT; j++) if (mb[j]) return 1;
    for (int i = 0; i < ND; i++) if (pend[i] || disk_ack[i]) return 1;
    return 0;
  endfunction

  initial begin
    logic [DW-1:0] x;
    int loops;
    rst_n = 1'b0; wr_valid = 1'b0; wr_lba = '0; wr_data = '0;
    disk_ack = '0; disk_rdata = '0;
    for (int j = 0; j < NSLOT; j++) begin mb[j] = 0; mexp[j] = 0; end
    for (int i = 0; i < ND; i++) begin pend[i] = 0; lat[i] = 0; end
    for (int s = 0; s < NSTR; s++) begin
      x = '0;
      for (int i = 0; i < ND; i++)
        if (i != pdisk_of(s)) begin mem[i][s] = DW'($urandom); x ^= mem[i][s]; end
      mem[pdisk_of(s)][s] = x;
    end
    for (int b = 0; b < NBLK; b++) img[b] = mem[ddisk_of(b)][b / 4];

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(disk_req == 0, "R10 no request in reset", disk_req, 0);
    chk(wr_done == 0, "R10 no done in reset", wr_done, 0);
    chk(wr_ready == 1'b1, "R10 ready in reset", wr_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: disjoint pair {0,4} and {2,3}; then lba 1 overlaps the first (R8)
    q_lba.push_back(0);  q_dat.push_back(16'h1111);
    q_lba.push_back(6);  q_dat.push_back(16'h2222);
    q_lba.push_back(1);  q_dat.push_back(16'h3333);
    // R1/R2 mapping corners: parity on disk 0, 4, 1; k at both ends
    q_lba.push_back(16); q_dat.push_back(16'h4444);
    q_lba.push_back(19); q_dat.push_back(16'h5555);
    q_lba.push_back(20); q_dat.push_back(16'h6666);
    q_lba.push_back(63); q_dat.push_back(16'h7777);
    q_lba.push_back(13); q_dat.push_back(16'h8888);
    q_lba.push_back(6);  q_dat.push_back(16'h9999);
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(4, 0) == 0) begin q_lba.push_back(-1); q_dat.push_back('0); end
      else begin q_lba.push_back(int'($urandom_range(NBLK - 1, 0))); q_dat.push_back(DW'($urandom)); end
    end

    loops = 0;
    while ((q_lba.size() > 0 || hold || busy_any()) && loops < 20000) begin
      step();
      loops++;
    end
    repeat (4) step();

    // R4 parity invariant and R2 data placement after drain
    for (int s = 0; s < NSTR; s++) begin
      x = '0;
      for (int i = 0; i < ND; i++) x ^= mem[i][s];
      chk(x == 0, "R4 stripe parity", x, 0);
    end
    for (int b = 0; b < NBLK; b++)
      chk(mem[ddisk_of(b)][b / 4] == img[b], "R2 data placement", mem[ddisk_of(b)][b / 4], img[b]);
    chk(ovl > 0, "R7 concurrent disjoint writes", ovl, 1);
    chk(stalls > 0, "R8 stall on overlap", stalls, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule